// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block tracks the operating mode of a digital phase-locked loop used for network timing. It holds one of five modes: freerun, normal, pin-selected holdover, auto-holdover and short-time holdover. A pair of mode-request pins chooses among normal, holdover and freerun. An invalid-reference flag and a reference-select transient pulse, both produced elsewhere, force automatic transitions that override the pins.

The block also gates the time-interval-error (TIE) control enable. That enable is cleared on every mode change except a return to normal from one of the three holdover modes, where the TIE enable pin decides its value. The block registers a one-hot set of status flags, and it shows a fast-lock indication while in normal mode.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: In normal (state code 1) with no transient and `ref_ok` low, the next state is auto-holdover (code 3), whatever `mode_req` holds.
- R2: In auto-holdover with no transient and `ref_ok` high, the next state is normal.
- R3: A transient (`sel_glitch` high) in normal or auto-holdover moves the block to short-time holdover (code 4) and clears `tie_act`. A transient takes priority over an invalid reference.
- R4: In short-time holdover the block returns to normal in the cycle after `sel_glitch` is low, and stays while it is high. The pins are ignored there.
- R5: A change of state clears `tie_act`, unless it goes from holdover (code 2), auto-holdover or short-time holdover into normal. On those changes `tie_act` takes the value of `tie_pin`. Without a change of state, `tie_act` holds its value.
- R6: The registered flags are one-hot. `flag_normal` is high in normal. `flag_hold` is high in holdover, auto-holdover and short-time holdover. `flag_free` is high in freerun (code 0).
- R7: `fast_lock` is high exactly when the state is normal and `flock_req` is high.
- R8: `mode_req` encoding: 00 normal, 01 holdover, 1x freerun. It applies in freerun and holdover, in normal when `ref_ok` is high and there is no transient, and in auto-holdover when `ref_ok` is low and there is no transient. In auto-holdover, a request for normal keeps the state unchanged.
- R9: Reset (`rst_n` low) gives state freerun, `flag_free` high, the other flags low, and `tie_act` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 2 | Pin-selected mode request |
| ref_ok | input | 1 | Reference valid flag |
| sel_glitch | input | 1 | Reference-select transient pulse |
| tie_pin | input | 1 | TIE enable pin |
| flock_req | input | 1 | Fast-lock request |
| state | output | 3 | Current mode code |
| flag_normal | output | 1 | Normal mode flag |
| flag_hold | output | 1 | Any holdover mode flag |
| flag_free | output | 1 | Freerun flag |
| tie_act | output | 1 | TIE control enable |
| fast_lock | output | 1 | Fast-lock indication |

## Verification
The assertions check on every cycle the detector-driven transitions, the one-hot flags and their agreement with the state, and both TIE gating rules. Only the bench's scenarios can show the parts that depend on sequences. These are the pin-selected modes under each state, a transient held high across several cycles, and the TIE pin value picked up when the block returns to normal from each holdover mode. They also include the reset values and long random mixes compared against the behavioural model.

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       ref_ok,
  input  logic       sel_glitch,
  input  logic       tie_pin,
  input  logic       flock_req,
  output logic [2:0] state,
  output logic       flag_normal,
  output logic       flag_hold,
  output logic       flag_free,
  output logic       tie_act,
  output logic       fast_lock
);
  localparam logic [2:0] S_FREE  = 3'd0;
  localparam logic [2:0] S_NORM  = 3'd1;
  localparam logic [2:0] S_HOLD  = 3'd2;
  localparam logic [2:0] S_AUTO  = 3'd3;
  localparam logic [2:0] S_SHORT = 3'd4;

  logic [2:0] nxt;
  logic [2:0] pin_mode;
  logic       tie_nxt;
  logic       from_hold;

  assign pin_mode = mode_req[1] ? S_FREE : (mode_req[0] ? S_HOLD : S_NORM);

  always_comb begin
    nxt = state;
    case (state)
      S_NORM:  if (sel_glitch)   nxt = S_SHORT;
               else if (!ref_ok) nxt = S_AUTO;
               else              nxt = pin_mode;
      S_AUTO:  if (sel_glitch)   nxt = S_SHORT;
               else if (ref_ok)  nxt = S_NORM;
               else if (pin_mode != S_NORM) nxt = pin_mode;
      S_SHORT: if (!sel_glitch)  nxt = S_NORM;
      S_HOLD,
      S_FREE:  nxt = pin_mode;
      default: nxt = S_FREE;
    endcase
  end

  assign from_hold = (state == S_HOLD) || (state == S_AUTO) || (state == S_SHORT);
  assign tie_nxt   = (nxt == state) ? tie_act : ((nxt == S_NORM) && from_hold && tie_pin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_FREE;
      tie_act     <= 1'b0;
      flag_normal <= 1'b0;
      flag_hold   <= 1'b0;
      flag_free   <= 1'b1;
    end else begin
      state       <= nxt;
      tie_act     <= tie_nxt;
      flag_normal <= (nxt == S_NORM);
      flag_hold   <= (nxt == S_HOLD) || (nxt == S_AUTO) || (nxt == S_SHORT);
      flag_free   <= (nxt == S_FREE);
    end
  end

  assign fast_lock = (state == S_NORM) && flock_req;
endmodule

module dpll_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_ok,
  input logic       sel_glitch,
  input logic       tie_pin,
  input logic [2:0] state,
  input logic       flag_normal,
  input logic       flag_hold,
  input logic       flag_free,
  input logic       tie_act
);
  p_invalid_to_auto_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1 && !sel_glitch && !ref_ok) |=> state == 3'd3);

  p_auto_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 && !sel_glitch && ref_ok) |=> state == 3'd1);

  p_glitch_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == 3'd1 || state == 3'd3) && sel_glitch) |=> (state == 3'd4 && !tie_act));

  p_short_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && !sel_glitch) |=> state == 3'd1);

  p_short_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && sel_glitch) |=> state == 3'd4);

  p_tie_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 || state == 3'd3 || state == 3'd4) |=> (state != 3'd1 || tie_act == $past(tie_pin)));

  p_tie_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'd1 && !(state == 3'd2 || state == 3'd3 || state == 3'd4)) |=> (state == $past(state) || !tie_act));

  p_tie_clear_norm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1) |=> (state == 3'd1 || !tie_act));

  p_flags_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flag_normal, flag_hold, flag_free}) == 1);

  p_flags_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_normal == (state == 3'd1)) && (flag_free == (state == 3'd0)));
endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .sel_glitch(sel_glitch),
  .tie_pin(tie_pin), .state(state), .flag_normal(flag_normal),
  .flag_hold(flag_hold), .flag_free(flag_free), .tie_act(tie_act)
);

// File: tb/tb_dpll_mode_ctrl.sv
`timescale 1ns/1ps
module tb_dpll_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_req = 2'b10;
  logic       ref_ok = 1'b0;
  logic       sel_glitch = 1'b0;
  logic       tie_pin = 1'b0;
  logic       flock_req = 1'b0;
  logic [2:0] state;
  logic       flag_normal, flag_hold, flag_free, tie_act, fast_lock;

  integer checks = 0;
  integer errors = 0;
  integer m_st = 0;
  integer m_tie = 0;
  bit     done = 1'b0;

  always #4 clk = ~clk;

  dpll_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .ref_ok(ref_ok),
    .sel_glitch(sel_glitch), .tie_pin(tie_pin), .flock_req(flock_req),
    .state(state), .flag_normal(flag_normal), .flag_hold(flag_hold),
    .flag_free(flag_free), .tie_act(tie_act), .fast_lock(fast_lock)
  );

  task automatic chk(input string tag, input integer act, input integer exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic integer req_mode(input logic [1:0] r);
    if (r == 2'b00) return 1;
    if (r == 2'b01) return 2;
    return 0;
  endfunction

  task automatic model_step();
    integer n;
    n = m_st;
    if (m_st == 4) n = sel_glitch ? 4 : 1;
    else if (m_st == 1 || m_st == 3) begin
      if (sel_glitch) n = 4;
      else if (m_st == 1 && !ref_ok) n = 3;
      else if (m_st == 3 && ref_ok) n = 1;
      else if (m_st == 1) n = req_mode(mode_req);
      else if (req_mode(mode_req) != 1) n = req_mode(mode_req);
    end else n = req_mode(mode_req);
    if (n != m_st) m_tie = (n == 1 && (m_st == 2 || m_st == 3 || m_st == 4)) ? int'(tie_pin) : 0;
    m_st = n;
  endtask

  task automatic compare(input string ctx);
    chk({"R1/R2/R3/R4/R8 state ", ctx}, state, m_st);
    chk({"R5 tie_act ", ctx}, tie_act, m_tie);
    chk({"R6 flag_normal ", ctx}, flag_normal, m_st == 1);
    chk({"R6 flag_hold ", ctx}, flag_hold, m_st >= 2);
    chk({"R6 flag_free ", ctx}, flag_free, m_st == 0);
    chk({"R7 fast_lock ", ctx}, fast_lock, (m_st == 1) && flock_req);
  endtask

  task automatic step(input logic [1:0] mr, input logic ok, input logic gl,
                      input logic tp, input logic fl, input string ctx);
    @(negedge clk);
    mode_req = mr; ref_ok = ok; sel_glitch = gl; tie_pin = tp; flock_req = fl;
    @(posedge clk);
    model_step();
    #2;
    compare(ctx);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R9 reset state", state, 0);
    chk("R9 reset flag_free", flag_free, 1);
    chk("R9 reset flag_normal", flag_normal, 0);
    chk("R9 reset flag_hold", flag_hold, 0);
    chk("R9 reset tie_act", tie_act, 0);
    @(negedge clk); rst_n = 1'b1;
    m_st = 0; m_tie = 0;

    step(2'b00, 1, 0, 1, 0, "R8 freerun to normal");
    step(2'b00, 1, 0, 1, 1, "R7 fast lock in normal");
    step(2'b10, 0, 0, 1, 1, "R1 invalid beats pin freerun");
    step(2'b00, 0, 0, 1, 0, "R8 auto stays on normal request");
    step(2'b00, 1, 0, 1, 0, "R2 auto returns, R5 tie from pin");
    step(2'b00, 1, 1, 1, 0, "R3 transient from normal");
    step(2'b00, 1, 1, 0, 0, "R4 short holds under transient");
    step(2'b10, 0, 0, 1, 0, "R4 short exits, pins ignored, R5");
    step(2'b00, 0, 0, 0, 0, "R1 to auto");
    step(2'b00, 0, 1, 1, 0, "R3 transient from auto clears tie");
    step(2'b00, 1, 0, 0, 0, "R4 exit with tie_pin low");
    step(2'b01, 1, 0, 1, 0, "R8 pin holdover");
    step(2'b01, 1, 1, 1, 0, "R8 holdover ignores transient");
    step(2'b00, 1, 0, 1, 1, "R5 holdover to normal takes pin");
    step(2'b00, 1, 0, 0, 1, "R5 tie holds without change");
    step(2'b11, 1, 0, 1, 0, "R8 code 11 freerun clears tie");
    step(2'b00, 1, 0, 1, 0, "R5 freerun to normal clears tie");
    step(2'b00, 0, 1, 1, 0, "R3 transient beats invalid");
    step(2'b00, 0, 0, 1, 0, "R4 exit then normal");
    step(2'b00, 0, 0, 1, 0, "R1 to auto again");
    step(2'b01, 0, 0, 1, 0, "R8 auto to pin holdover");

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      step(r[1:0], (r[2] | r[3]), (r[4] & r[5] & r[3]), r[5], r[0] ^ r[4], "random mix");
    end

    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #2;
    chk("R9 reset after run state", state, 0);
    chk("R9 reset after run tie", tie_act, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule